// File: doc/BRIEF.md
# Lamp Strike and Fault Sequencer

This block is the control state machine for one fluorescent lamp channel. It takes digitized status flags (supply health, two supply-monitor comparisons, lamp current present, lamp current under the lamp-out level, voltage limit, overvoltage, overcurrent), one lamp-cycle tick and a few configuration inputs. From these it produces an 8-bit gate duty-cycle command, a gate driver enable, a state code and a latched fault flag. A separate modulator turns the duty command into gate pulses. Closed-loop current regulation happens outside the block. In the run state the block only applies single up or down trim requests.

The sequence runs as follows. The block waits for a qualified supply. It then raises the duty command slowly until the lamp conducts, and watches the lit lamp for lamp-out. When a strike or run attempt fails, the block either pauses and tries again, up to a bounded number of attempts, or latches a fault. A latched fault stays until power-down or supply loss removes qualification. Every timer counts lamp-cycle ticks, not clocks.

Top module: `lamp_seq`

## Requirements
- R1: State codes are OFF=0, STRIKE=1, RUN=2, WAIT=3, FAULT=4. The channel is qualified only when `vcc_ok`=1, `mon_lo_ok`=1, `mon_hi_over`=0 and `pdn_pin`, `sw_pdn`, `ch_dis` are all 0. OFF moves to STRIKE on the first clock edge at which the channel is qualified.
- R2: If qualification is lost while in STRIKE, RUN or WAIT, the state becomes OFF on the next edge and the gate enable drops.
- R3: On entering STRIKE the duty is `DUTY_MIN` (16). The duty rises by one on every 16th lamp tick counted from entry. A step is skipped if `v_lim` is high on that tick. The duty never exceeds `DUTY_MAX` (200).
- R4: In STRIKE, `lamp_on` moves the state to RUN on the next edge, and the duty keeps its value.
- R5: STRIKE without lamp current enters fault handling on the Nth lamp tick after entry. N is 1024, 2048, 4096 or 8192 for `to_sel` = 0, 1, 2 or 3. Clocks without `lamp_tick` do not count.
- R6: `ov_flag` in STRIKE enters fault handling on the next edge, and the gate enable drops.
- R7: In RUN, `lamp_low` is sampled on every Mth tick after entry, where M is 1, 2, 4 or 8 for `sr_sel` = 0, 1, 2 or 3. A sample with `lamp_low`=0 restarts the lamp-out count. If the count reaches the `to_sel` timeout, the block enters fault handling.
- R8: In RUN, on each tick: `trim_up` alone with `v_lim`=0 adds one, capped at `DUTY_MAX`. `trim_dn` alone subtracts one, floored at `DUTY_MIN`. Any other combination holds the duty.
- R9: Fault handling goes to WAIT when `retry_en`=1 and fewer than 14 retries have been used; otherwise it goes to FAULT. WAIT holds the duty at `DUTY_MIN` for 1024 ticks and then re-enters STRIKE. The retry count clears in OFF.
- R10: `oc_flag` in STRIKE or RUN moves the state to FAULT on the next edge, whatever `retry_en` is.
- R11: FAULT holds while the channel is qualified and moves to OFF as soon as it is not. `fault_o` is 1 only in FAULT.
- R12: During and after reset the state is OFF, the gate enable is low, the duty is `DUTY_MIN` and `fault_o` is low.
- R13: `gate_en_o` is high only in STRIKE and RUN, and it rises only on entry to STRIKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lamp_tick | input | 1 | One-clock pulse per lamp cycle |
| vcc_ok | input | 1 | Device supply above lockout level |
| mon_lo_ok | input | 1 | Low-side supply monitor above its threshold |
| mon_hi_over | input | 1 | High-side supply monitor above its threshold |
| pdn_pin | input | 1 | Power-down pin |
| sw_pdn | input | 1 | Software power-down bit |
| ch_dis | input | 1 | Channel disable bit |
| retry_en | input | 1 | Enable automatic retries |
| to_sel | input | 2 | Strike / lamp-out timeout select |
| sr_sel | input | 2 | Lamp current sample-rate select |
| lamp_on | input | 1 | Lamp current detected |
| lamp_low | input | 1 | Lamp current below lamp-out level |
| v_lim | input | 1 | Lamp voltage at its allowed limit |
| ov_flag | input | 1 | Overvoltage detected |
| oc_flag | input | 1 | Lamp overcurrent detected |
| trim_up | input | 1 | Run-state request to raise duty |
| trim_dn | input | 1 | Run-state request to lower duty |
| duty_o | output | 8 | Gate duty-cycle command |
| gate_en_o | output | 1 | Gate driver enable |
| state_o | output | 3 | Sequencer state code |
| fault_o | output | 1 | Latched permanent fault |

## Verification
Two pairs of events can land on the same edge. In the first, the 16th-tick ramp step meets an asserted voltage limit. The bench holds `v_lim` across two ramp steps and then requires the duty to have moved by exactly one step 16 ticks after release. In the second, the lamp-out sample point meets a short current recovery. With one sample in eight, the bench places a three-tick dip in `lamp_low` between sample points and requires the lamp-out fault on the 1024th tick exactly. Sampling on every tick would have kept the lamp in RUN.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_STRIKE = 3'd1,
      ST_RUN    = 3'd2,
      ST_WAIT   = 3'd3,
      ST_FAULT  = 3'd4
   } lseq_state_e;
endpackage

// File: rtl/lseq_timer.sv
// Shared tick counter: strike timeout, lamp-out window and retry pause.
module lseq_timer #(
   parameter int TO_BASE    = 1024,
   parameter int WAIT_TICKS = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       tick,
   input  logic       run_mode,
   input  logic [1:0] to_sel,
   input  logic [1:0] sr_sel,
   input  logic       lamp_low,
   output logic       to_hit,
   output logic       wait_hit
);
   localparam int MAX_TO = TO_BASE * 8;
   localparam int CW     = $clog2(MAX_TO) + 1;

   if (TO_BASE < 2) begin : g_bad_base
      $error("lseq_timer: TO_BASE must be at least 2");
   end
   if (WAIT_TICKS < 1 || WAIT_TICKS > MAX_TO) begin : g_bad_wait
      $error("lseq_timer: WAIT_TICKS out of range");
   end

   logic [CW-1:0] lim [4];
   for (genvar k = 0; k < 4; k++) begin : g_lim
      localparam int LIM_K = (TO_BASE << k) - 1;
      assign lim[k] = LIM_K[CW-1:0];
   end

   localparam int WAIT_M1 = WAIT_TICKS - 1;

   logic [CW-1:0] cnt;
   logic [2:0]    scnt;
   logic [2:0]    mask;
   logic          samp;
   logic          seen;

   always_comb begin
      case (sr_sel)
         2'd0:    mask = 3'b000;
         2'd1:    mask = 3'b001;
         2'd2:    mask = 3'b011;
         default: mask = 3'b111;
      endcase
   end

   assign samp = tick & ((scnt & mask) == mask);
   assign seen = run_mode & samp & ~lamp_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         scnt <= '0;
      end else if (clr) begin
         cnt  <= '0;
         scnt <= '0;
      end else if (tick) begin
         scnt <= scnt + 3'd1;
         cnt  <= seen ? '0 : cnt + CW'(1);
      end
   end

   assign to_hit   = tick & ~seen & (cnt == lim[to_sel]);
   assign wait_hit = tick & (cnt == WAIT_M1[CW-1:0]);
endmodule

// File: rtl/lseq_duty.sv
// Duty command: slow ramp in strike, single-step trims in run.
module lseq_duty #(
   parameter int DUTY_W     = 8,
   parameter int DUTY_MIN   = 16,
   parameter int DUTY_MAX   = 200,
   parameter int RAMP_TICKS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ramp_en,
   input  logic              trim_en,
   input  logic              hold_en,
   input  logic              tick,
   input  logic              v_lim,
   input  logic              up,
   input  logic              dn,
   output logic [DUTY_W-1:0] duty
);
   localparam int RW = (RAMP_TICKS > 1) ? $clog2(RAMP_TICKS) : 1;
   localparam logic [DUTY_W-1:0] D_MIN = DUTY_MIN[DUTY_W-1:0];
   localparam logic [DUTY_W-1:0] D_MAX = DUTY_MAX[DUTY_W-1:0];

   if (DUTY_MIN >= DUTY_MAX || DUTY_MAX >= (1 << DUTY_W)) begin : g_bad_duty
      $error("lseq_duty: need DUTY_MIN < DUTY_MAX < 2**DUTY_W");
   end
   if (RAMP_TICKS < 1 || (RAMP_TICKS & (RAMP_TICKS - 1)) != 0) begin : g_bad_ramp
      $error("lseq_duty: RAMP_TICKS must be a power of two");
   end

   logic [RW-1:0] rcnt;
   logic          ramp_pt;

   if (RAMP_TICKS == 1) begin : g_ramp_every
      assign ramp_pt = tick;
   end else begin : g_ramp_div
      localparam int RLAST = RAMP_TICKS - 1;
      assign ramp_pt = tick & (rcnt == RLAST[RW-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty <= D_MIN;
         rcnt <= '0;
      end else if (ramp_en) begin
         if (tick) rcnt <= rcnt + RW'(1);
         if (ramp_pt && !v_lim && duty < D_MAX) duty <= duty + DUTY_W'(1);
      end else if (trim_en) begin
         rcnt <= '0;
         if (tick) begin
            if (up && !dn && !v_lim && duty < D_MAX)      duty <= duty + DUTY_W'(1);
            else if (dn && !up && duty > D_MIN)          duty <= duty - DUTY_W'(1);
         end
      end else if (hold_en) begin
         rcnt <= '0;
      end else begin
         rcnt <= '0;
         duty <= D_MIN;
      end
   end
endmodule

// File: rtl/lamp_seq.sv
module lamp_seq
   import lseq_pkg::*;
#(
   parameter int DUTY_W     = 8,
   parameter int DUTY_MIN   = 16,
   parameter int DUTY_MAX   = 200,
   parameter int RAMP_TICKS = 16,
   parameter int TO_BASE    = 1024,
   parameter int RETRY_MAX  = 14,
   parameter int RETRY_WAIT = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lamp_tick,
   input  logic              vcc_ok,
   input  logic              mon_lo_ok,
   input  logic              mon_hi_over,
   input  logic              pdn_pin,
   input  logic              sw_pdn,
   input  logic              ch_dis,
   input  logic              retry_en,
   input  logic [1:0]        to_sel,
   input  logic [1:0]        sr_sel,
   input  logic              lamp_on,
   input  logic              lamp_low,
   input  logic              v_lim,
   input  logic              ov_flag,
   input  logic              oc_flag,
   input  logic              trim_up,
   input  logic              trim_dn,
   output logic [DUTY_W-1:0] duty_o,
   output logic              gate_en_o,
   output logic [2:0]        state_o,
   output logic              fault_o
);
   localparam int RCW = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;

   if (RETRY_MAX < 0) begin : g_bad_retry
      $error("lamp_seq: RETRY_MAX must not be negative");
   end

   lseq_state_e st_q, st_d;
   logic        qual;
   logic        retry_ok;
   logic        to_hit, wait_hit;
   lseq_state_e fail_st;

   assign qual    = vcc_ok & mon_lo_ok & ~mon_hi_over & ~pdn_pin & ~sw_pdn & ~ch_dis;
   assign fail_st = retry_ok ? ST_WAIT : ST_FAULT;

   always_comb begin
      st_d = st_q;
      if (!qual) begin
         st_d = ST_OFF;
      end else begin
         case (st_q)
            ST_OFF:    st_d = ST_STRIKE;
            ST_STRIKE: begin
               if (oc_flag)      st_d = ST_FAULT;
               else if (ov_flag) st_d = fail_st;
               else if (lamp_on) st_d = ST_RUN;
               else if (to_hit)  st_d = fail_st;
            end
            ST_RUN: begin
               if (oc_flag)      st_d = ST_FAULT;
               else if (to_hit)  st_d = fail_st;
            end
            ST_WAIT:   if (wait_hit) st_d = ST_STRIKE;
            ST_FAULT:  st_d = ST_FAULT;
            default:   st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   if (RETRY_MAX > 0) begin : g_retry
      localparam logic [RCW-1:0] R_LIM = RETRY_MAX[RCW-1:0];
      logic [RCW-1:0] used_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 used_q <= '0;
         else if (st_q == ST_OFF)                    used_q <= '0;
         else if (st_d == ST_WAIT && st_q != ST_WAIT) used_q <= used_q + RCW'(1);
      end
      assign retry_ok = retry_en & (used_q < R_LIM);
   end else begin : g_no_retry
      assign retry_ok = 1'b0;
   end

   lseq_timer #(
      .TO_BASE    (TO_BASE),
      .WAIT_TICKS (RETRY_WAIT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (st_d != st_q),
      .tick     (lamp_tick),
      .run_mode (st_q == ST_RUN),
      .to_sel   (to_sel),
      .sr_sel   (sr_sel),
      .lamp_low (lamp_low),
      .to_hit   (to_hit),
      .wait_hit (wait_hit)
   );

   lseq_duty #(
      .DUTY_W     (DUTY_W),
      .DUTY_MIN   (DUTY_MIN),
      .DUTY_MAX   (DUTY_MAX),
      .RAMP_TICKS (RAMP_TICKS)
   ) u_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .ramp_en (st_q == ST_STRIKE && st_d == ST_STRIKE),
      .trim_en (st_q == ST_RUN && st_d == ST_RUN),
      .hold_en (st_q == ST_STRIKE && st_d == ST_RUN),
      .tick    (lamp_tick),
      .v_lim   (v_lim),
      .up      (trim_up),
      .dn      (trim_dn),
      .duty    (duty_o)
   );

   assign gate_en_o = (st_q == ST_STRIKE) || (st_q == ST_RUN);
   assign state_o   = st_q;
   assign fault_o   = (st_q == ST_FAULT);
endmodule

// File: rtl/lseq_chk.sv
module lseq_chk
   import lseq_pkg::*;
#(
   parameter int DUTY_W   = 8,
   parameter int DUTY_MIN = 16,
   parameter int DUTY_MAX = 200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vcc_ok,
   input logic              mon_lo_ok,
   input logic              mon_hi_over,
   input logic              pdn_pin,
   input logic              sw_pdn,
   input logic              ch_dis,
   input logic              lamp_on,
   input logic              v_lim,
   input logic              ov_flag,
   input logic              oc_flag,
   input logic [DUTY_W-1:0] duty_o,
   input logic              gate_en_o,
   input logic [2:0]        state_o
);
   logic q;
   assign q = vcc_ok & mon_lo_ok & ~mon_hi_over & ~pdn_pin & ~sw_pdn & ~ch_dis;

   assert_unqual_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && state_o != ST_OFF) |=> state_o == ST_OFF);

   assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (q && state_o == ST_FAULT) |=> state_o == ST_FAULT);

   assert_ocp_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q && oc_flag && (state_o == ST_STRIKE || state_o == ST_RUN)) |=> state_o == ST_FAULT);

   assert_ovp_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (q && ov_flag && state_o == ST_STRIKE) |=> !gate_en_o);

   assert_duty_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_o >= DUTY_W'(DUTY_MIN)) && (duty_o <= DUTY_W'(DUTY_MAX)));

   assert_vlim_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_STRIKE && v_lim) |=> (state_o != ST_STRIKE) || (duty_o == $past(duty_o)));

   assert_strike_to_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !oc_flag && !ov_flag && lamp_on && state_o == ST_STRIKE)
         |=> (state_o == ST_RUN) && (duty_o == $past(duty_o)));

   assert_gate_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en_o) |-> (state_o == ST_STRIKE) &&
                           ($past(state_o) == ST_OFF || $past(state_o) == ST_WAIT));

   assert_wait_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_WAIT) |-> (!gate_en_o && duty_o == DUTY_W'(DUTY_MIN)));
endmodule

bind lamp_seq lseq_chk #(
   .DUTY_W   (DUTY_W),
   .DUTY_MIN (DUTY_MIN),
   .DUTY_MAX (DUTY_MAX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .vcc_ok      (vcc_ok),
   .mon_lo_ok   (mon_lo_ok),
   .mon_hi_over (mon_hi_over),
   .pdn_pin     (pdn_pin),
   .sw_pdn      (sw_pdn),
   .ch_dis      (ch_dis),
   .lamp_on     (lamp_on),
   .v_lim       (v_lim),
   .ov_flag     (ov_flag),
   .oc_flag     (oc_flag),
   .duty_o      (duty_o),
   .gate_en_o   (gate_en_o),
   .state_o     (state_o)
);

// File: tb/tb_lamp_seq.sv
module tb_lamp_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lamp_tick = 1'b1;
   logic       vcc_ok = 1'b0, mon_lo_ok = 1'b0, mon_hi_over = 1'b0;
   logic       pdn_pin = 1'b0, sw_pdn = 1'b0, ch_dis = 1'b0, retry_en = 1'b0;
   logic [1:0] to_sel = 2'd0, sr_sel = 2'd0;
   logic       lamp_on = 1'b0, lamp_low = 1'b0, v_lim = 1'b0;
   logic       ov_flag = 1'b0, oc_flag = 1'b0, trim_up = 1'b0, trim_dn = 1'b0;
   logic [7:0] duty_o;
   logic       gate_en_o, fault_o;
   logic [2:0] state_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   lamp_seq dut (
      .clk(clk), .rst_n(rst_n), .lamp_tick(lamp_tick),
      .vcc_ok(vcc_ok), .mon_lo_ok(mon_lo_ok), .mon_hi_over(mon_hi_over),
      .pdn_pin(pdn_pin), .sw_pdn(sw_pdn), .ch_dis(ch_dis), .retry_en(retry_en),
      .to_sel(to_sel), .sr_sel(sr_sel), .lamp_on(lamp_on), .lamp_low(lamp_low),
      .v_lim(v_lim), .ov_flag(ov_flag), .oc_flag(oc_flag),
      .trim_up(trim_up), .trim_dn(trim_dn),
      .duty_o(duty_o), .gate_en_o(gate_en_o), .state_o(state_o), .fault_o(fault_o)
   );

   localparam logic [2:0] S_OFF = 3'd0, S_STR = 3'd1, S_RUN = 3'd2, S_WAIT = 3'd3, S_FLT = 3'd4;

   typedef struct packed {
      logic [2:0]  sup;   // {vcc_ok, mon_lo_ok, mon_hi_over}
      logic [2:0]  shut;  // {pdn_pin, sw_pdn, ch_dis}
      logic        lon;
      logic        llow;
      logic        ovp;
      logic        ocp;
      logic        rty;
      logic [15:0] n;
      logic [2:0]  est;
      logic        egate;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{3'b100, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2,    S_OFF,  1'b0, 4'd1 },  // R1 low monitor under
      '{3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2,    S_OFF,  1'b0, 4'd1 },  // R1 high monitor over
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_STR,  1'b1, 4'd1 },  // R1 start
      '{3'b110, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_RUN,  1'b1, 4'd4 },  // R4 struck
      '{3'b110, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2000, S_RUN,  1'b1, 4'd7 },  // R7 lamp healthy
      '{3'b110, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1023, S_RUN,  1'b1, 4'd7 },  // R7 not yet out
      '{3'b110, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    S_FLT,  1'b0, 4'd7 },  // R7 lamp out
      '{3'b110, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd50,   S_FLT,  1'b0, 4'd11},  // R11 latched
      '{3'b110, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_OFF,  1'b0, 4'd11},  // R11 sw clear
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_STR,  1'b1, 4'd1 },
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1,    S_FLT,  1'b0, 4'd6 },  // R6 overvoltage
      '{3'b110, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_OFF,  1'b0, 4'd11},  // R11 disable clear
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_STR,  1'b1, 4'd1 },
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1023, S_STR,  1'b1, 4'd5 },  // R5 before timeout
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_FLT,  1'b0, 4'd5 },  // R5 timeout
      '{3'b110, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_OFF,  1'b0, 4'd11},  // R11 pin clear
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd1,    S_STR,  1'b1, 4'd1 },
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd1,    S_FLT,  1'b0, 4'd10},  // R10 no retry
      '{3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_OFF,  1'b0, 4'd11},  // R11 UVLO clear
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_STR,  1'b1, 4'd1 },
      '{3'b010, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_OFF,  1'b0, 4'd2 },  // R2 supply lost
      '{3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_STR,  1'b1, 4'd1 },
      '{3'b110, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_RUN,  1'b1, 4'd4 },
      '{3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,    S_OFF,  1'b0, 4'd2 }   // R2 monitor over
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic check(input int req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic qualify();
      {vcc_ok, mon_lo_ok, mon_hi_over} = 3'b110;
      {pdn_pin, sw_pdn, ch_dis} = 3'b000;
   endtask

   task automatic bounce();  // pass through OFF and re-enter STRIKE
      sw_pdn = 1'b1; step(1);
      sw_pdn = 1'b0; step(1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL R12 watchdog: actual timeout expected end of run");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      #5;
      step(3);
      check(12, "reset state", state_o, S_OFF);
      check(12, "reset gate", gate_en_o, 0);
      check(12, "reset duty", duty_o, 16);
      check(12, "reset fault", fault_o, 0);
      rst_n = 1'b1;
      step(2);
      check(12, "post-reset state", state_o, S_OFF);

      for (int i = 0; i < NV; i++) begin
         {vcc_ok, mon_lo_ok, mon_hi_over} = VEC[i].sup;
         {pdn_pin, sw_pdn, ch_dis}        = VEC[i].shut;
         lamp_on  = VEC[i].lon;
         lamp_low = VEC[i].llow;
         ov_flag  = VEC[i].ovp;
         oc_flag  = VEC[i].ocp;
         retry_en = VEC[i].rty;
         step(int'(VEC[i].n));
         check(int'(VEC[i].req), $sformatf("vector %0d state/gate/fault", i),
               int'({state_o, gate_en_o, fault_o}),
               int'({VEC[i].est, VEC[i].egate, VEC[i].est == S_FLT}));
      end
      lamp_on = 1'b0; lamp_low = 1'b0; ov_flag = 1'b0; oc_flag = 1'b0;

      // R9: fourteen retries, then latch
      qualify(); retry_en = 1'b1; to_sel = 2'd0;
      step(1);
      check(9, "retry start", state_o, S_STR);
      for (int a = 0; a <= 14; a++) begin
         step(1023);
         check(5, "strike before timeout", state_o, S_STR);
         step(1);
         if (a < 14) begin
            check(9, "enter wait", state_o, S_WAIT);
            check(13, "gate off in wait", gate_en_o, 0);
            check(9, "duty in wait", duty_o, 16);
            step(1023);
            check(9, "still waiting", state_o, S_WAIT);
            step(1);
            check(9, "retry strike", state_o, S_STR);
         end else begin
            check(9, "retries exhausted", state_o, S_FLT);
         end
      end
      // R9: count clears in OFF
      ch_dis = 1'b1; step(1);
      check(11, "disable clears fault", state_o, S_OFF);
      ch_dis = 1'b0; step(1);
      step(1024);
      check(9, "retry count reset", state_o, S_WAIT);

      // R5: no ticks, no progress; 2048-tick select
      retry_en = 1'b0;
      bounce();
      lamp_tick = 1'b0;
      step(3000);
      check(5, "no tick state", state_o, S_STR);
      check(3, "no tick duty", duty_o, 16);
      lamp_tick = 1'b1; to_sel = 2'd1;
      step(2047);
      check(5, "2048 select before", state_o, S_STR);
      step(1);
      check(5, "2048 select timeout", state_o, S_FLT);

      // R3: ramp, voltage-limit hold, saturation
      to_sel = 2'd3;
      bounce();
      check(3, "strike entry duty", duty_o, 16);
      step(16);
      check(3, "first step", duty_o, 17);
      v_lim = 1'b1; step(32);
      check(3, "held at limit", duty_o, 17);
      v_lim = 1'b0; step(16);
      check(3, "ramp resumes", duty_o, 18);
      step(2912);
      check(3, "reaches max", duty_o, 200);
      step(100);
      check(3, "saturated", duty_o, 200);

      // R4 and R8
      lamp_on = 1'b1; step(1);
      check(4, "struck state", state_o, S_RUN);
      check(4, "duty kept", duty_o, 200);
      lamp_on = 1'b0;
      trim_up = 1'b1; step(5);
      check(8, "trim up capped", duty_o, 200);
      trim_up = 1'b0; trim_dn = 1'b1; step(3);
      check(8, "trim down", duty_o, 197);
      trim_dn = 1'b0; trim_up = 1'b1; v_lim = 1'b1; step(2);
      check(8, "up blocked by limit", duty_o, 197);
      v_lim = 1'b0; step(2);
      check(8, "trim up", duty_o, 199);
      trim_dn = 1'b1; step(2);
      check(8, "both held", duty_o, 199);
      trim_up = 1'b0; step(300);
      check(8, "trim floor", duty_o, 16);
      trim_dn = 1'b0;

      // R7: dip between sample points with 1-in-8 sampling is not seen
      to_sel = 2'd0; sr_sel = 2'd3;
      bounce();
      lamp_on = 1'b1; step(1);
      check(7, "run entry", state_o, S_RUN);
      lamp_on = 1'b0; lamp_low = 1'b1; step(1020);
      lamp_low = 1'b0; step(3);
      check(7, "run before sample", state_o, S_RUN);
      lamp_low = 1'b1; step(1);
      check(7, "lamp out at sample", state_o, S_FLT);
      check(11, "fault flag", fault_o, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule